// File: doc/BRIEF.md
# I2C Master Control Front-End

This block sits between software and the bit-level engine of an I2C master. Software reaches it through a small register port with a two-bit register select. Through that port it sets an enable bit and a master-mode bit, and it programs the target address together with a flag that selects 10-bit addressing. It queues bus commands by writing a byte and a read/write command bit into a transmit command FIFO. The engine takes commands from that FIFO over a valid/ready handshake. It returns received bytes into a receive FIFO, which software drains by reading the data register.

The block decides whether a target-address update is accepted. While the controller is enabled, the address may only change when the bus is quiet, the block is in master mode and no command is waiting. It also tracks shutdown. After software clears the enable bit, an active-status bit stays high until the engine reports that its current transfer has finished. On the cycle the engine goes idle, both FIFOs are flushed and the status bit drops. While disabled, the FIFOs stay empty and data-register writes are discarded.

Register map (select value: register): 0 control (bit 0 enable, bit 1 master mode); 1 target (bits 9:0 address, bit 12 ten-bit flag); 2 data (write: bits 7:0 byte, bit 8 command; read: received byte); 3 status.

Top module: `i2c_mctl_frontend`

## Requirements
- R1: After reset, the control register reads 0x0002 (master mode 1, enable 0), the target register reads 0x0000, the status register reads 0x0004 and the data register reads 0x0000.
- R2: Data-register writes made while the enable bit is 0 queue nothing. While enable is 0 and `eng_busy` is 0, both FIFOs are held empty.
- R3: A write to the target register while enable is 0 always updates the address (bits 9:0) and the ten-bit flag (bit 12), as seen on readback and on `tgt_addr`/`tgt_ten_bit`.
- R4: While enable is 1, a target write takes effect only when `eng_busy` is 0, master mode is 1 and the transmit FIFO is empty. Otherwise the write leaves the target register unchanged.
- R5: A data-register write while enabled queues one command: bits 7:0 carry the byte and bit 8 carries the command (0 = write the byte, 1 = read, byte ignored). Commands reach `cmd_byte`/`cmd_read` in the order written, with reads and writes freely mixed.
- R6: The transmit FIFO holds 8 commands. A data write while it is full is dropped and sets a sticky overflow flag (status bit 4). Reading the status register clears this flag on the following cycle.
- R7: `ctrl_active` (status bit 0) becomes 1 on the clock edge after the one that sets the enable bit.
- R8: After enable is cleared, `ctrl_active` stays 1 and queued commands are kept while `eng_busy` is 1. On the first edge where enable is 0 and `eng_busy` is 0, `ctrl_active` goes to 0 and both FIFOs are flushed.
- R9: The status bits are: 0 active, 1 `eng_busy`, 2 TX empty, 3 TX full, 4 overflow, 5 RX not empty.
- R10: A byte offered on `rx_valid`/`rx_byte` while `ctrl_active` is 1 is stored. Reading the data register returns {bit 8 = 1, byte} and pops it. Reading an empty receive FIFO returns 0x0000.
- R11: `cmd_valid` is asserted only while `ctrl_active` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX data, clears overflow) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| eng_busy | input | 1 | Engine reports a transfer in progress |
| cmd_valid | output | 1 | A command is offered to the engine |
| cmd_ready | input | 1 | Engine accepts the offered command |
| cmd_byte | output | 8 | Byte of the offered command |
| cmd_read | output | 1 | Offered command is a read |
| rx_valid | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| tgt_addr | output | 10 | Current target address |
| tgt_ten_bit | output | 1 | Ten-bit addressing selected |
| master_mode | output | 1 | Master mode selected |
| ctrl_active | output | 1 | Enable status: controller not yet shut down |

## Verification
The bench targets the target-address gate one condition at a time: a queued command, a busy engine and slave mode each block the update, and a design that checked only some of them would take one of those writes. It holds the engine busy across a disable. A design that reports shutdown early, or that flushes before the engine goes idle, shows `ctrl_active` low or an empty FIFO too soon. It pushes a ninth command to hit the full boundary: a design that overwrote an entry would break scoreboard order, and one that cleared the overflow flag too early would miss the sticky bit. Writes made while disabled must never reach the engine.

// File: rtl/i2c_mctl_pkg.sv
package i2c_mctl_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_TARGET = 2'd1,
        SEL_DATA   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_POS  = 0;
    localparam int CTRL_MM_POS  = 1;
    localparam int TGT_TEN_POS  = 12;

    localparam int ST_ACTIVE_POS = 0;
    localparam int ST_BUSY_POS   = 1;
    localparam int ST_TXE_POS    = 2;
    localparam int ST_TXF_POS    = 3;
    localparam int ST_OVF_POS    = 4;
    localparam int ST_RXNE_POS   = 5;

endpackage

// File: rtl/i2c_mctl_fifo.sv
module i2c_mctl_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    // DEPTH is expected to be a power of two: pointers wrap naturally.
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wp] = wdata;
                st_d.wp           = st_q.wp + AW'(1);
            end
            if (do_pop) begin
                st_d.rp = st_q.rp + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.mem[st_q.rp];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/i2c_mctl_shutdown.sv
module i2c_mctl_shutdown (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic eng_busy,
    output logic active,
    output logic flush
);
    logic active_d, active_q;

    always_comb begin
        if (enable) begin
            active_d = 1'b1;
        end else if (eng_busy) begin
            active_d = active_q;
        end else begin
            active_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= active_d;
        end
    end

    assign active = active_q;
    assign flush  = !enable && !eng_busy;

endmodule

// File: rtl/i2c_mctl_tar_gate.sv
module i2c_mctl_tar_gate (
    input  logic enable,
    input  logic eng_busy,
    input  logic master_mode,
    input  logic tx_empty,
    output logic accept
);
    logic quiet_master;

    always_comb begin
        quiet_master = !eng_busy && master_mode && tx_empty;
        accept       = !enable || quiet_master;
    end

endmodule

// File: rtl/i2c_mctl_frontend.sv
module i2c_mctl_frontend
    import i2c_mctl_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TAR_W    = 10,
    parameter int REG_W    = 16,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_busy,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_read,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic [TAR_W-1:0]  tgt_addr,
    output logic              tgt_ten_bit,
    output logic              master_mode,
    output logic              ctrl_active
);
    localparam int CMD_POS = DATA_W;
    localparam int CMD_W   = DATA_W + 1;

    typedef struct packed {
        logic             enable;
        logic             mmode;
        logic [TAR_W-1:0] tar;
        logic             ten;
        logic             ovf;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{enable: 1'b0, mmode: 1'b1, tar: '0, ten: 1'b0, ovf: 1'b0};

    ctl_t ctl_d, ctl_q;

    reg_sel_e          sel;
    logic              wr_ctrl, wr_tgt, data_wr, rd_status, rx_pop;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic [CMD_W-1:0]  tx_wdata, tx_rdata;
    logic              rx_push, rx_empty, rx_full;
    logic [DATA_W-1:0] rx_rdata;
    logic              tar_ok, flush, stat_bit;
    logic              en_bit, mm_bit, ovf_bit;
    logic [TAR_W:0]    tar_word;
    logic              unused_in;

    assign en_bit   = ctl_q.enable;
    assign mm_bit   = ctl_q.mmode;
    assign ovf_bit  = ctl_q.ovf;
    assign tar_word = {ctl_q.ten, ctl_q.tar};

    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        wr_ctrl   = reg_wr && (sel == SEL_CTRL);
        wr_tgt    = reg_wr && (sel == SEL_TARGET);
        data_wr   = reg_wr && (sel == SEL_DATA);
        rd_status = reg_rd && (sel == SEL_STATUS);
        rx_pop    = reg_rd && (sel == SEL_DATA);
        tx_push   = data_wr && en_bit;
        tx_wdata  = {reg_wdata[CMD_POS], reg_wdata[DATA_W-1:0]};
        tx_pop    = cmd_valid && cmd_ready;
        rx_push   = rx_valid && stat_bit;

        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.enable = reg_wdata[CTRL_EN_POS];
            ctl_d.mmode  = reg_wdata[CTRL_MM_POS];
        end
        if (wr_tgt && tar_ok) begin
            ctl_d.tar = reg_wdata[TAR_W-1:0];
            ctl_d.ten = reg_wdata[TGT_TEN_POS];
        end
        if (rd_status) begin
            ctl_d.ovf = 1'b0;
        end
        if (tx_push && tx_full) begin
            ctl_d.ovf = 1'b1;
        end

        reg_rdata = '0;
        case (sel)
            SEL_CTRL: begin
                reg_rdata[CTRL_EN_POS] = en_bit;
                reg_rdata[CTRL_MM_POS] = mm_bit;
            end
            SEL_TARGET: begin
                reg_rdata[TAR_W-1:0]  = tar_word[TAR_W-1:0];
                reg_rdata[TGT_TEN_POS] = tar_word[TAR_W];
            end
            SEL_DATA: begin
                if (!rx_empty) begin
                    reg_rdata[DATA_W-1:0] = rx_rdata;
                    reg_rdata[CMD_POS]    = 1'b1;
                end
            end
            default: begin
                reg_rdata[ST_ACTIVE_POS] = stat_bit;
                reg_rdata[ST_BUSY_POS]   = eng_busy;
                reg_rdata[ST_TXE_POS]    = tx_empty;
                reg_rdata[ST_TXF_POS]    = tx_full;
                reg_rdata[ST_OVF_POS]    = ovf_bit;
                reg_rdata[ST_RXNE_POS]   = !rx_empty;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    i2c_mctl_shutdown u_shut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (en_bit),
        .eng_busy (eng_busy),
        .active   (stat_bit),
        .flush    (flush)
    );

    i2c_mctl_tar_gate u_gate (
        .enable      (en_bit),
        .eng_busy    (eng_busy),
        .master_mode (mm_bit),
        .tx_empty    (tx_empty),
        .accept      (tar_ok)
    );

    i2c_mctl_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (tx_pop),
        .rdata (tx_rdata),
        .empty (tx_empty),
        .full  (tx_full)
    );

    i2c_mctl_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign cmd_valid   = stat_bit && !tx_empty;
    assign cmd_byte    = tx_rdata[DATA_W-1:0];
    assign cmd_read    = tx_rdata[CMD_POS];
    assign tgt_addr    = tar_word[TAR_W-1:0];
    assign tgt_ten_bit = tar_word[TAR_W];
    assign master_mode = mm_bit;
    assign ctrl_active = stat_bit;
    assign unused_in   = ^{reg_wdata, rx_full};

endmodule

// File: rtl/i2c_mctl_checker.sv
module i2c_mctl_checker #(
    parameter int TAR_W = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           en_bit,
    input logic           mm_bit,
    input logic           stat_bit,
    input logic           eng_busy,
    input logic           tx_empty,
    input logic           tx_full,
    input logic           ovf_bit,
    input logic           data_wr,
    input logic           cmd_valid,
    input logic [TAR_W:0] tar_word
);

    AST_ACTIVE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        en_bit |=> stat_bit); // R7

    AST_SHUTDOWN_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit && eng_busy && stat_bit) |=> stat_bit); // R8

    AST_SHUTDOWN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_bit && !eng_busy) |=> (!stat_bit && tx_empty)); // R2

    AST_TARGET_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_bit && (eng_busy || !mm_bit || !tx_empty)) |=> $stable(tar_word)); // R4

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && en_bit && tx_full) |=> ovf_bit); // R6

    AST_CMD_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> stat_bit); // R11

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty)); // R6

endmodule

bind i2c_mctl_frontend i2c_mctl_checker #(.TAR_W(TAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_bit    (en_bit),
    .mm_bit    (mm_bit),
    .stat_bit  (stat_bit),
    .eng_busy  (eng_busy),
    .tx_empty  (tx_empty),
    .tx_full   (tx_full),
    .ovf_bit   (ovf_bit),
    .data_wr   (data_wr),
    .cmd_valid (cmd_valid),
    .tar_word  (tar_word)
);

// File: tb/i2c_mctl_frontend_test.sv
module i2c_mctl_frontend_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_busy = 1'b0;
    logic        cmd_valid, cmd_ready = 1'b0;
    logic [7:0]  cmd_byte;
    logic        cmd_read;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [9:0]  tgt_addr;
    logic        tgt_ten_bit, master_mode, ctrl_active;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_en = 0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mctl_frontend uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .cmd_read(cmd_read), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tgt_addr(tgt_addr), .tgt_ten_bit(tgt_ten_bit),
        .master_mode(master_mode), .ctrl_active(ctrl_active)
    );

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic read_check(string tag, logic [1:0] a, logic [15:0] exp);
        logic [15:0] v;
        reg_read(a, v);
        check(tag, v, exp);
    endtask

    // Driver: writes a command and records what the engine should see.
    task automatic push_cmd(logic [7:0] b, logic rd);
        reg_write(2'd2, {7'd0, rd, b});
        if (model_en && exp_q.size() < 8) exp_q.push_back({rd, b});
    endtask

    task automatic drain(string tag);
        cmd_ready = 1'b1;
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        cmd_ready = 1'b0;
        check(tag, 16'(exp_q.size()), 16'd0);
    endtask

    // Monitor: compares every accepted command against the queue.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected command", {7'd0, cmd_read, cmd_byte}, 16'hFFFF);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    if (e[8]) check("R5 read command", {15'd0, cmd_read}, 16'd1);
                    else      check("R5 write command", {7'd0, cmd_read, cmd_byte}, {7'd0, e});
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9 reset values
        read_check("R1 ctrl reset", 2'd0, 16'h0002);
        read_check("R1 target reset", 2'd1, 16'h0000);
        read_check("R1 R9 status reset", 2'd3, 16'h0004);
        read_check("R1 data reset", 2'd2, 16'h0000);

        // R3 target write while disabled
        reg_write(2'd1, 16'h12AB);
        read_check("R3 target readback", 2'd1, 16'h12AB);
        check("R3 tgt_addr port", {6'd0, tgt_addr}, 16'h02AB);
        check("R3 ten-bit port", {15'd0, tgt_ten_bit}, 16'd1);

        // R2 data writes while disabled are discarded
        push_cmd(8'h11, 1'b0);
        push_cmd(8'h22, 1'b1);

        // R7 enable status timing
        reg_write(2'd0, 16'h0003);
        #1 check("R7 active not yet", {15'd0, ctrl_active}, 16'd0);
        @(negedge clk);
        #1 check("R7 active after one edge", {15'd0, ctrl_active}, 16'd1);
        model_en = 1;
        read_check("R2 nothing queued", 2'd3, 16'h0005);
        check("R2 R11 no command offered", {15'd0, cmd_valid}, 16'd0);

        // R5 mixed commands, R4 blocked by queued entries
        push_cmd(8'hA5, 1'b0);
        push_cmd(8'hFF, 1'b1);
        push_cmd(8'h3C, 1'b0);
        push_cmd(8'h00, 1'b1);
        read_check("R9 status queued", 2'd3, 16'h0001);
        reg_write(2'd1, 16'h0055);
        read_check("R4 blocked by queued cmds", 2'd1, 16'h12AB);
        drain("R5 all commands delivered");
        read_check("R5 queue empty after drain", 2'd3, 16'h0005);

        // R4 blocked by busy engine, then by slave mode, then accepted
        @(negedge clk); eng_busy = 1'b1;
        read_check("R9 busy bit", 2'd3, 16'h0007);
        reg_write(2'd1, 16'h0011);
        read_check("R4 blocked by busy", 2'd1, 16'h12AB);
        @(negedge clk); eng_busy = 1'b0;
        reg_write(2'd0, 16'h0001);
        check("R4 master_mode port low", {15'd0, master_mode}, 16'd0);
        reg_write(2'd1, 16'h0022);
        read_check("R4 blocked by slave mode", 2'd1, 16'h12AB);
        reg_write(2'd0, 16'h0003);
        reg_write(2'd1, 16'h0033);
        read_check("R4 accepted when quiet", 2'd1, 16'h0033);

        // R6 overflow
        for (int i = 0; i < 9; i++) push_cmd(8'(8'h40 + i), 1'b0);
        read_check("R6 full and overflow", 2'd3, 16'h0019);
        read_check("R6 overflow cleared by read", 2'd3, 16'h0009);
        drain("R6 eight commands in order");

        // R8 shutdown waits for engine
        push_cmd(8'h81, 1'b0);
        push_cmd(8'h82, 1'b1);
        @(negedge clk); eng_busy = 1'b1;
        reg_write(2'd0, 16'h0002);
        model_en = 0;
        repeat (3) @(negedge clk);
        read_check("R8 still active while busy", 2'd3, 16'h0003);
        @(negedge clk); eng_busy = 1'b0;
        #1 check("R8 active until edge", {15'd0, ctrl_active}, 16'd1);
        @(negedge clk);
        #1 check("R8 active drops", {15'd0, ctrl_active}, 16'd0);
        check("R11 no command after shutdown", {15'd0, cmd_valid}, 16'd0);
        exp_q.delete();
        read_check("R8 R2 fifos flushed", 2'd3, 16'h0004);

        // R10 receive path
        reg_write(2'd0, 16'h0003);
        model_en = 1;
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h5A;
        @(negedge clk); rx_byte = 8'hC3;
        @(negedge clk); rx_valid = 1'b0;
        read_check("R10 R9 rx not empty", 2'd3, 16'h0025);
        read_check("R10 first byte", 2'd2, 16'h015A);
        read_check("R10 second byte", 2'd2, 16'h01C3);
        read_check("R10 empty read", 2'd2, 16'h0000);
        read_check("R10 status after pops", 2'd3, 16'h0005);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule